// File: doc/BRIEF.md
# Distributed DRAM Refresh Scheduler

This block paces single-row refresh operations for a DRAM array. Each row gets one refresh per retention window. The refreshes are spread evenly through that window, so the array never stalls for a long burst. The refresh spacing and the length of each refresh are given in physical units (retention window, row count, refresh duration), and the block turns them into clock-cycle counts from a clock-frequency parameter. A row pointer advances after each refresh and wraps at the last row.

The block also sits between a host access port and the refresh engine. It grants the host with a ready/valid handshake. A granted access stays in flight until the host reports completion. A refresh whose time has come waits for that in-flight access to finish, and it then takes priority over any new host request. While a refresh runs, the host is held off for the exact busy window.

A mode input halves the retention window. The refresh spacing is then halved for the same row count. A per-window counter reports how many refreshes were issued in the last completed window.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, ref_busy, ref_done, host_ready, ref_row and ref_per_win are all 0. The first refresh (row 0) raises ref_busy after the third rising clock edge that follows reset release.
- R2: With no host traffic, successive refreshes start exactly INT = CLK_MHZ*RET_US/ROWS cycles apart (integer division).
- R3: ref_busy stays high for exactly ceil(BUSY_NS*CLK_MHZ/1000) consecutive cycles per refresh.
- R4: host_ready is 0 in every cycle in which ref_busy is 1.
- R5: ref_done is a one-cycle pulse, high in the first cycle after ref_busy falls and at no other time.
- R6: ref_row holds the row being refreshed while ref_busy is high. It advances by one when the refresh ends, wrapping from ROWS-1 to 0, and is otherwise unchanged.
- R7: A refresh never starts while a granted host access is in flight. When host_done is asserted for one cycle, a due refresh raises ref_busy two edges later.
- R8: Once a refresh is due, host_ready stays 0 until that refresh has finished. host_ready returns to 1 in the ref_done cycle when no host access is in flight.
- R9: With half_ret = 1, successive refreshes with no host traffic start INT/2 cycles apart.
- R10: With no host traffic, ref_per_win reports ROWS at the end of each window. The window is ROWS*INT cycles long, or ROWS*INT/2 cycles with half_ret = 1.
- R11: A grant happens on a clock edge where host_valid and host_ready are both 1. host_ready is 0 from the next cycle until host_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_ret | input | 1 | 1 selects the halved retention window (double refresh rate) |
| host_valid | input | 1 | Host requests an access |
| host_ready | output | 1 | Host access may be granted this cycle |
| host_done | input | 1 | Granted host access completes (one cycle) |
| ref_busy | output | 1 | A refresh occupies the array |
| ref_done | output | 1 | One-cycle pulse after a refresh ends |
| ref_row | output | $clog2(ROWS) | Row being refreshed, or the next row to refresh |
| ref_per_win | output | $clog2(ROWS+2) | Refreshes issued in the last completed window |

## Verification
The hardest case to reach from the ports is a refresh that falls due while a host access is in flight. From outside, the pending refresh can only be seen indirectly: host_ready stays low and ref_busy rises two edges after host_done. The bench waits for a refresh to end, grants an access at once, and holds it in flight for longer than a full interval, so the timer is sure to expire underneath it. It then releases the access and checks the exact cycle at which the refresh starts. A random phase with variable access lengths then checks the cases that no directed test lines up. In that phase, no refresh may ever start in a cycle where the bench's own model shows an access in flight.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;
  // cycles between refresh starts for an evenly spread schedule
  function automatic int interval_cycles(input int clk_mhz, input int ret_us, input int rows);
    return (clk_mhz * ret_us) / rows;
  endfunction
  // refresh occupancy rounded up to whole cycles
  function automatic int busy_cycles(input int busy_ns, input int clk_mhz);
    return (busy_ns * clk_mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/ref_timer.sv
`timescale 1ns/1ps
module ref_timer #(
  parameter int INT_FULL = 1562,
  parameter int INT_HALF = 781,
  parameter int W        = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_ret,
  input  logic issue,
  output logic due
);
  logic [W-1:0] tmr_q, tmr_d;
  logic         pend_q, pend_d;
  logic         zero;

  assign zero = (tmr_q == '0);
  assign due  = pend_q | zero;

  always_comb begin
    tmr_d  = tmr_q;
    pend_d = pend_q;
    if (issue) begin
      tmr_d  = half_ret ? W'(INT_HALF - 1) : W'(INT_FULL - 1);
      pend_d = 1'b0;
    end else if (zero) begin
      pend_d = 1'b1;
    end else begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ref_exec.sv
`timescale 1ns/1ps
module ref_exec #(
  parameter int BUSY_CYC = 15,
  parameter int ROWS     = 8192,
  parameter int ROW_W    = 13,
  parameter int BW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  output logic             busy,
  output logic             done,
  output logic [ROW_W-1:0] row
);
  logic             busy_q, busy_d, done_q, done_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    busy_d = busy_q;
    bcnt_d = bcnt_q;
    row_d  = row_q;
    done_d = 1'b0;
    if (issue) begin
      busy_d = 1'b1;
      bcnt_d = BW'(BUSY_CYC - 1);
    end else if (busy_q) begin
      if (bcnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        row_d  = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end else begin
        bcnt_d = bcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      done_q <= 1'b0;
      row_q  <= '0;
    end else begin
      busy_q <= busy_d;
      bcnt_q <= bcnt_d;
      done_q <= done_d;
      row_q  <= row_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign row  = row_q;
endmodule

// File: rtl/ref_window.sv
`timescale 1ns/1ps
module ref_window #(
  parameter int WIN_FULL = 12795904,
  parameter int WIN_HALF = 6397952,
  parameter int WW       = 24,
  parameter int CW       = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_ret,
  input  logic          issue,
  output logic [CW-1:0] per_win
);
  logic [WW-1:0] wt_q, wt_d;
  logic [CW-1:0] cnt_q, cnt_d, pw_q, pw_d;
  logic          last;

  assign last = (wt_q >= (half_ret ? WW'(WIN_HALF - 1) : WW'(WIN_FULL - 1)));

  always_comb begin
    wt_d  = wt_q + 1'b1;
    cnt_d = cnt_q + CW'(issue);
    pw_d  = pw_q;
    if (last) begin
      wt_d  = '0;
      pw_d  = cnt_q + CW'(issue);
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_q  <= '0;
      cnt_q <= '0;
      pw_q  <= '0;
    end else begin
      wt_q  <= wt_d;
      cnt_q <= cnt_d;
      pw_q  <= pw_d;
    end
  end

  assign per_win = pw_q;
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int RET_US  = 64000,
  parameter int ROWS    = 8192,
  parameter int BUSY_NS = 75
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      half_ret,
  input  logic                      host_valid,
  output logic                      host_ready,
  input  logic                      host_done,
  output logic                      ref_busy,
  output logic                      ref_done,
  output logic [$clog2(ROWS)-1:0]   ref_row,
  output logic [$clog2(ROWS+2)-1:0] ref_per_win
);
  localparam int INT_FULL = interval_cycles(CLK_MHZ, RET_US, ROWS);
  localparam int INT_HALF = INT_FULL / 2;
  localparam int BUSY_CYC = busy_cycles(BUSY_NS, CLK_MHZ);
  localparam int WIN_FULL = INT_FULL * ROWS;
  localparam int WIN_HALF = INT_HALF * ROWS;
  localparam int ROW_W    = $clog2(ROWS);
  localparam int CW       = $clog2(ROWS + 2);
  localparam int TW       = $clog2(INT_FULL + 1);
  localparam int BW       = $clog2(BUSY_CYC + 1);
  localparam int WW       = $clog2(WIN_FULL + 1);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic due, issue, busy;
  logic infl_q, infl_d, grant;

  assign host_ready = rs_n & ~busy & ~due & ~infl_q;
  assign grant      = host_valid & host_ready;
  assign issue      = due & ~busy & ~infl_q;

  always_comb begin
    infl_d = infl_q;
    if (grant)          infl_d = 1'b1;
    else if (host_done) infl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) infl_q <= 1'b0;
    else       infl_q <= infl_d;
  end

  ref_timer #(.INT_FULL(INT_FULL), .INT_HALF(INT_HALF), .W(TW)) u_timer (
    .clk(clk), .rst_n(rs_n), .half_ret(half_ret), .issue(issue), .due(due)
  );

  ref_exec #(.BUSY_CYC(BUSY_CYC), .ROWS(ROWS), .ROW_W(ROW_W), .BW(BW)) u_exec (
    .clk(clk), .rst_n(rs_n), .issue(issue), .busy(busy), .done(ref_done), .row(ref_row)
  );

  ref_window #(.WIN_FULL(WIN_FULL), .WIN_HALF(WIN_HALF), .WW(WW), .CW(CW)) u_win (
    .clk(clk), .rst_n(rs_n), .half_ret(half_ret), .issue(issue), .per_win(ref_per_win)
  );

  assign ref_busy = busy;
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
  parameter int BUSY_CYC = 15,
  parameter int ROWS     = 8192,
  parameter int ROW_W    = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_ready,
  input logic             ref_busy,
  input logic             ref_done,
  input logic [ROW_W-1:0] ref_row
);
  localparam int LW = $clog2(BUSY_CYC + 2);
  logic [LW-1:0]    blen;
  logic [ROW_W-1:0] row_prev, row_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen     <= '0;
      row_prev <= '0;
    end else begin
      blen     <= ref_busy ? blen + 1'b1 : '0;
      row_prev <= ref_row;
    end
  end

  assign row_step = (row_prev == ROW_W'(ROWS - 1)) ? '0 : row_prev + 1'b1;

  p_ready_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !host_ready);
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> (blen == LW'(BUSY_CYC)));
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (!ref_busy && $past(ref_busy)));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ref_row == row_step));
  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_done |-> $stable(ref_row));
endmodule

bind refresh_sched refresh_sched_chk #(.BUSY_CYC(BUSY_CYC), .ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .ref_busy(ref_busy),
  .ref_done(ref_done), .ref_row(ref_row)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  localparam int CLK_MHZ = 200;
  localparam int RET_US  = 8;
  localparam int ROWS    = 16;
  localparam int BUSY_NS = 75;

  logic clk = 1'b0;
  logic rst_n, half_ret, host_valid, host_done;
  logic host_ready, ref_busy, ref_done;
  logic [3:0] ref_row;
  logic [4:0] ref_per_win;

  always #2.5 clk = ~clk;

  refresh_sched #(.CLK_MHZ(CLK_MHZ), .RET_US(RET_US), .ROWS(ROWS), .BUSY_NS(BUSY_NS)) dut (
    .clk(clk), .rst_n(rst_n), .half_ret(half_ret), .host_valid(host_valid),
    .host_ready(host_ready), .host_done(host_done), .ref_busy(ref_busy),
    .ref_done(ref_done), .ref_row(ref_row), .ref_per_win(ref_per_win)
  );

  function automatic int exp_int(input bit half);
    int v = (CLK_MHZ * RET_US) / ROWS;
    return half ? v / 2 : v;
  endfunction
  function automatic int exp_busy();
    return (BUSY_NS * CLK_MHZ + 999) / 1000;
  endfunction

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  bit quiet, prev_busy, infl;
  int last_rise, blen, model_row;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock; sampled at the falling edge, then the monitor runs
  task automatic step();
    bit g, d, pre;
    g = host_valid && host_ready;
    d = host_done;
    pre = infl;
    @(negedge clk);
    cyc++;
    infl = g ? 1'b1 : (d ? 1'b0 : infl);
    if (g) chk("R11 ready low after grant", host_ready, 0);
    if (ref_busy && !prev_busy) begin
      if (quiet && last_rise >= 0) chk(half_ret ? "R9 half interval" : "R2 interval",
                                       cyc - last_rise, exp_int(half_ret));
      chk("R6 row at refresh start", ref_row, model_row);
      chk("R7 no refresh while access in flight", pre, 0);
      last_rise = cyc;
      blen = 0;
    end
    if (ref_busy) begin
      blen++;
      if (host_ready) chk("R4 ready while busy", host_ready, 0);
    end
    if (!ref_busy && prev_busy) begin
      chk("R3 busy length", blen, exp_busy());
      chk("R5 done after busy", ref_done, 1);
      model_row = (model_row + 1) % ROWS;
      chk("R6 row advance/wrap", ref_row, model_row);
    end else if (ref_done) begin
      chk("R5 stray done", ref_done, 0);
    end
    prev_busy = ref_busy;
  endtask

  task automatic do_reset(input bit half);
    rst_n = 1'b0; half_ret = half; host_valid = 0; host_done = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", ref_busy, 0);
    chk("R1 done in reset", ref_done, 0);
    chk("R1 ready in reset", host_ready, 0);
    chk("R1 row in reset", ref_row, 0);
    chk("R1 per_win in reset", ref_per_win, 0);
    rst_n = 1'b1;
    prev_busy = 0; infl = 0; last_rise = -1; blen = 0; model_row = 0;
    step(); step();
    chk("R1 no refresh before third edge", ref_busy, 0);
    step();
    chk("R1 first refresh at third edge", ref_busy, 1);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    quiet = 1;
    // full-rate schedule, two windows
    do_reset(0);
    repeat (2 * exp_int(0) * ROWS + 40) step();
    chk("R10 per-window count full", ref_per_win, ROWS);

    // halved window
    do_reset(1);
    repeat (2 * exp_int(1) * ROWS + 40) step();
    chk("R10 per-window count half", ref_per_win, ROWS);

    // refresh falls due under an in-flight access
    quiet = 0;
    do_reset(0);
    while (!ref_done) step();
    chk("R8 ready back after refresh", host_ready, 1);
    host_valid = 1;
    step();
    host_valid = 0;
    for (int i = 0; i < exp_int(0) + 30; i++) begin
      step();
      chk("R7 refresh held by access", ref_busy, 0);
      chk("R8 ready low while pending", host_ready, 0);
    end
    host_done = 1;
    step();
    host_done = 0;
    chk("R7 not yet started", ref_busy, 0);
    step();
    chk("R7 starts two edges after done", ref_busy, 1);
    while (!ref_done) begin
      host_valid = 1;
      step();
    end
    host_valid = 0;
    chk("R8 ready at done cycle", host_ready, 1);

    // random host traffic
    do_reset(0);
    for (int i = 0; i < 3000; i++) begin
      if (infl) begin
        host_valid = 0;
        host_done  = ($urandom % 6) == 0;
      end else begin
        host_done  = 0;
        host_valid = ($urandom % 3) != 0;
      end
      step();
    end
    host_valid = 0; host_done = 0;
    repeat (5) step();

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule